// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells the out-of-order core whether a memory instruction has to wait for an older store that is still in flight. It chains two tables. The identifier table is indexed by bits of the instruction address and names the store set that address belongs to. The set table is indexed by that set identifier and remembers the sequence number and thread of the most recently fetched store of the set. Every entry of both tables has its own valid bit.

Violation reports train the identifier table by placing a store and a load in a common set. Store insertion records the newest store of a set. Store issue and per-thread squash retire set-table entries by sequence number. A global clear forgets everything. Dependence lookups are a valid/ready stream. A request is accepted when `lk_valid` and `lk_ready` are both high. The answer is held in a one-entry output register until the consumer raises `rsp_ready`. A new request is accepted only while that register is empty or is being drained in the same cycle.

The table sizes are powers of two. Sequence numbers compare as plain unsigned values, so a larger number is younger. The value 0 means "no dependence" and is never used as a store's sequence number.

Top module: `ssp_predictor`

## Requirements
- R1: After reset, `rsp_valid` is low, `lk_ready` is high and every table entry is invalid, so any lookup returns 0.
- R2: The identifier-table index is `(pc >> PC_OFFSET) mod ID_ENTRIES` (PC_OFFSET=2, ID_ENTRIES=64 by default). A newly formed set identifier is `(pc XOR (pc >> 10)) mod SET_ENTRIES` (SET_ENTRIES=16).
- R3: A lookup returns the stored sequence number only when the identifier entry for its PC is valid and the set entry it names is valid. Otherwise it returns 0.
- R4: Inserting a store writes its sequence number and thread into the set entry only when the store's identifier entry is valid. Otherwise the insertion has no effect.
- R5: On a violation where neither PC has a valid identifier entry, both entries become valid with the identifier hashed from the store PC.
- R6: On a violation where exactly one of the two entries is valid, the other entry takes a copy of the valid identifier.
- R7: On a violation where both entries are valid, both take the numerically smaller of the two identifiers.
- R8: A store issue clears the set entry of the issuing store's set only when that entry holds the same sequence number.
- R9: A squash for thread T at sequence number N clears every valid set entry of thread T whose sequence number is greater than N. Entries of other threads are untouched.
- R10: Clear invalidates every entry of both tables at the next edge. It overrides insertion, violation, issue and squash in the same cycle.
- R11: The response appears one cycle after acceptance. It reflects the table contents from before any update made in the acceptance cycle.
- R12: `lk_ready` is `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_seq` hold steady.
- R13: When an insertion and an issue or squash hit the same set entry in one cycle, the insertion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Invalidate both tables |
| ins_valid | input | 1 | Store insertion strobe |
| ins_pc | input | PC_W | PC of inserted store |
| ins_seq | input | SEQ_W | Sequence number of inserted store |
| ins_tid | input | TID_W | Thread of inserted store |
| vio_valid | input | 1 | Ordering violation strobe |
| vio_store_pc | input | PC_W | PC of the older store |
| vio_load_pc | input | PC_W | PC of the load that ran too early |
| iss_valid | input | 1 | Store issue strobe |
| iss_pc | input | PC_W | PC of issuing store |
| iss_seq | input | SEQ_W | Sequence number of issuing store |
| sq_valid | input | 1 | Squash strobe |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_pc | input | PC_W | PC to look up |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_seq | output | SEQ_W | Producer store sequence number, 0 if none |

## Verification
The bench aims at the three violation merge cases. A design that picks the larger identifier would leave a trained load pointing at an empty set, and its lookup would return 0 instead of the store's number. It drives issue with a stale sequence number and squash exactly at the boundary number and for the wrong thread. A design that compares loosely would drop a live producer. It also drives insertion together with lookup, issue or clear in one cycle, where getting the ordering wrong shows up as a new number too early, an entry lost, or training that survives the clear. Finally it holds `rsp_ready` low while the table changes underneath, to catch a response register that re-samples.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Right shift folded into the PC before a new set identifier is formed.
  localparam int unsigned HASH_FOLD = 10;
endpackage

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned ENTRIES   = 64,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned PC_OFFSET = 2,
  parameter int unsigned RD_PORTS  = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              vio_en,
  input  logic [PC_W-1:0]                   vio_st_pc,
  input  logic [PC_W-1:0]                   vio_ld_pc,
  input  logic [RD_PORTS-1:0][PC_W-1:0]     rd_pc,
  output logic [RD_PORTS-1:0]               rd_hit,
  output logic [RD_PORTS-1:0][ID_W-1:0]     rd_id,
  output logic [ENTRIES-1:0]                vld_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]           vld;
  logic [ENTRIES-1:0][ID_W-1:0] ids;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[PC_OFFSET +: IDX_W];
  endfunction

  function automatic logic [ID_W-1:0] hash_of(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] f;
    f = pc ^ (pc >> ssp_pkg::HASH_FOLD);
    return f[ID_W-1:0];
  endfunction

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_hit[p] = vld[idx_of(rd_pc[p])];
    assign rd_id[p]  = ids[idx_of(rd_pc[p])];
  end

  logic [IDX_W-1:0] st_i, ld_i;
  logic             st_v, ld_v;
  logic [ID_W-1:0]  new_id;

  always_comb begin
    st_i = idx_of(vio_st_pc);
    ld_i = idx_of(vio_ld_pc);
    st_v = vld[st_i];
    ld_v = vld[ld_i];
    unique case ({st_v, ld_v})
      2'b00:   new_id = hash_of(vio_st_pc);
      2'b10:   new_id = ids[st_i];
      2'b01:   new_id = ids[ld_i];
      default: new_id = (ids[st_i] < ids[ld_i]) ? ids[st_i] : ids[ld_i];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      vld <= '0;
      ids <= '0;
    end else if (vio_en) begin
      vld[st_i] <= 1'b1;
      vld[ld_i] <= 1'b1;
      ids[st_i] <= new_id;
      ids[ld_i] <= new_id;
    end
  end

  assign vld_o = vld;
endmodule

// File: rtl/ssp_set_table.sv
module ssp_set_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned SEQ_W   = 16,
  parameter int unsigned TID_W   = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            ins_en,
  input  logic [$clog2(ENTRIES)-1:0]      ins_set,
  input  logic [SEQ_W-1:0]                ins_seq,
  input  logic [TID_W-1:0]                ins_tid,
  input  logic                            iss_en,
  input  logic [$clog2(ENTRIES)-1:0]      iss_set,
  input  logic [SEQ_W-1:0]                iss_seq,
  input  logic                            sq_en,
  input  logic [TID_W-1:0]                sq_tid,
  input  logic [SEQ_W-1:0]                sq_seq,
  output logic [ENTRIES-1:0]              vld_o,
  output logic [ENTRIES-1:0][SEQ_W-1:0]   seq_o
);
  logic [ENTRIES-1:0][TID_W-1:0] tid;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic ins_me, iss_me, sq_me;
    assign ins_me = ins_en && (ins_set == e);
    assign iss_me = iss_en && (iss_set == e) && (seq_o[e] == iss_seq);
    assign sq_me  = sq_en && (tid[e] == sq_tid) && (seq_o[e] > sq_seq);

    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        vld_o[e] <= 1'b0;
        seq_o[e] <= '0;
        tid[e]   <= '0;
      end else if (ins_me) begin
        vld_o[e] <= 1'b1;
        seq_o[e] <= ins_seq;
        tid[e]   <= ins_tid;
      end else if (iss_me || sq_me) begin
        vld_o[e] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor #(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned THREADS     = 2,
  parameter int unsigned ID_ENTRIES  = 64,
  parameter int unsigned SET_ENTRIES = 16,
  parameter int unsigned PC_OFFSET   = 2,
  localparam int unsigned ID_W  = $clog2(SET_ENTRIES),
  localparam int unsigned TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ins_valid,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [TID_W-1:0] ins_tid,
  input  logic             vio_valid,
  input  logic [PC_W-1:0]  vio_store_pc,
  input  logic [PC_W-1:0]  vio_load_pc,
  input  logic             iss_valid,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_valid,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [SEQ_W-1:0] rsp_seq
);
  localparam int unsigned RD_LK  = 0;
  localparam int unsigned RD_INS = 1;
  localparam int unsigned RD_ISS = 2;
  localparam int unsigned RDN    = 3;

  logic [RDN-1:0]                 rd_hit;
  logic [RDN-1:0][ID_W-1:0]       rd_id;
  logic [RDN-1:0][PC_W-1:0]       rd_pc;
  logic [ID_ENTRIES-1:0]          id_vld;
  logic [SET_ENTRIES-1:0]         set_vld;
  logic [SET_ENTRIES-1:0][SEQ_W-1:0] set_seq;

  assign rd_pc[RD_LK]  = lk_pc;
  assign rd_pc[RD_INS] = ins_pc;
  assign rd_pc[RD_ISS] = iss_pc;

  ssp_id_table #(
    .PC_W(PC_W), .ENTRIES(ID_ENTRIES), .ID_W(ID_W),
    .PC_OFFSET(PC_OFFSET), .RD_PORTS(RDN)
  ) u_ids (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .vio_en(vio_valid), .vio_st_pc(vio_store_pc), .vio_ld_pc(vio_load_pc),
    .rd_pc(rd_pc), .rd_hit(rd_hit), .rd_id(rd_id), .vld_o(id_vld)
  );

  ssp_set_table #(
    .ENTRIES(SET_ENTRIES), .SEQ_W(SEQ_W), .TID_W(TID_W)
  ) u_sets (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .ins_en(ins_valid && rd_hit[RD_INS]), .ins_set(rd_id[RD_INS]),
    .ins_seq(ins_seq), .ins_tid(ins_tid),
    .iss_en(iss_valid && rd_hit[RD_ISS]), .iss_set(rd_id[RD_ISS]),
    .iss_seq(iss_seq),
    .sq_en(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .vld_o(set_vld), .seq_o(set_seq)
  );

  logic             lk_fire;
  logic [SEQ_W-1:0] lk_result;

  assign lk_ready  = !rsp_valid || rsp_ready;
  assign lk_fire   = lk_valid && lk_ready;
  assign lk_result = (rd_hit[RD_LK] && set_vld[rd_id[RD_LK]]) ? set_seq[rd_id[RD_LK]] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_seq   <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_seq   <= lk_result;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ssp_predictor_chk.sv
module ssp_predictor_chk #(
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned ID_ENTRIES  = 64,
  parameter int unsigned SET_ENTRIES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clear,
  input logic                   lk_valid,
  input logic                   lk_ready,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [SEQ_W-1:0]       rsp_seq,
  input logic [ID_ENTRIES-1:0]  id_vld,
  input logic [SET_ENTRIES-1:0] set_vld
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rsp_valid && id_vld == '0 && set_vld == '0));

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (id_vld == '0 && set_vld == '0));

  assert_empty_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear ##1 (lk_valid && lk_ready) |=> (rsp_seq == '0));

  assert_accept_responds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  assert_hold_response_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_seq)));

  assert_stall_only_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ready |-> rsp_valid);
endmodule

bind ssp_predictor ssp_predictor_chk #(
  .SEQ_W(SEQ_W), .ID_ENTRIES(ID_ENTRIES), .SET_ENTRIES(SET_ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_seq(rsp_seq),
  .id_vld(id_vld), .set_vld(set_vld)
);

// File: tb/tb_ssp_predictor.sv
`timescale 1ns/1ps
module tb_ssp_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_pc = '0;
  logic [15:0] ins_seq = '0;
  logic [0:0]  ins_tid = '0;
  logic        vio_valid = 1'b0;
  logic [31:0] vio_store_pc = '0, vio_load_pc = '0;
  logic        iss_valid = 1'b0;
  logic [31:0] iss_pc = '0;
  logic [15:0] iss_seq = '0;
  logic        sq_valid = 1'b0;
  logic [0:0]  sq_tid = '0;
  logic [15:0] sq_seq = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_pc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_seq;

  int n_chk = 0, n_fail = 0;

  ssp_predictor dut (.*);

  always #4 clk = ~clk;

  // Behavioural reference model
  int m_ssv[64], m_ssid[64], m_lv[16], m_lseq[16], m_ltid[16];
  int e_v = 0, e_s = 0;

  function automatic int midx(input logic [31:0] pc); return int'((pc >> 2) & 32'd63); endfunction
  function automatic int mhash(input logic [31:0] pc); return int'((pc ^ (pc >> 10)) & 32'd15); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin m_ssv[i] = 0; m_ssid[i] = 0; end
      for (int i = 0; i < 16; i++) begin m_lv[i] = 0; m_lseq[i] = 0; m_ltid[i] = 0; end
      e_v = 0; e_s = 0;
    end else begin
      int r, ih, is_, sh, ss, a, b, nid;
      bit fire;
      fire = lk_valid && (e_v == 0 || rsp_ready);
      r = 0;
      if (m_ssv[midx(lk_pc)] != 0 && m_lv[m_ssid[midx(lk_pc)]] != 0) r = m_lseq[m_ssid[midx(lk_pc)]];
      ih = m_ssv[midx(ins_pc)]; is_ = m_ssid[midx(ins_pc)];
      sh = m_ssv[midx(iss_pc)]; ss = m_ssid[midx(iss_pc)];
      if (clear) begin
        for (int i = 0; i < 64; i++) m_ssv[i] = 0;
        for (int i = 0; i < 16; i++) m_lv[i] = 0;
      end else begin
        if (vio_valid) begin
          a = midx(vio_store_pc); b = midx(vio_load_pc);
          if (m_ssv[a] == 0 && m_ssv[b] == 0) nid = mhash(vio_store_pc);
          else if (m_ssv[b] == 0) nid = m_ssid[a];
          else if (m_ssv[a] == 0) nid = m_ssid[b];
          else nid = (m_ssid[a] < m_ssid[b]) ? m_ssid[a] : m_ssid[b];
          m_ssv[a] = 1; m_ssv[b] = 1; m_ssid[a] = nid; m_ssid[b] = nid;
        end
        if (iss_valid && sh != 0 && m_lseq[ss] == int'(iss_seq)) m_lv[ss] = 0;
        if (sq_valid)
          for (int i = 0; i < 16; i++)
            if (m_lv[i] != 0 && m_ltid[i] == int'(sq_tid) && m_lseq[i] > int'(sq_seq)) m_lv[i] = 0;
        if (ins_valid && ih != 0) begin
          m_lv[is_] = 1; m_lseq[is_] = int'(ins_seq); m_ltid[is_] = int'(ins_tid);
        end
      end
      if (fire) begin e_v = 1; e_s = r; end
      else if (rsp_ready) e_v = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(rsp_valid == (e_v != 0), "R11 rsp_valid vs model", int'(rsp_valid), e_v);
      if (e_v != 0) check(int'(rsp_seq) == e_s, "R3 rsp_seq vs model", int'(rsp_seq), e_s);
      check(lk_ready == (e_v == 0 || rsp_ready), "R12 lk_ready vs model", int'(lk_ready), int'(e_v == 0 || rsp_ready));
    end
  end

  task automatic tick; @(negedge clk); #1; endtask

  task automatic do_ins(input logic [31:0] pc, input int seq, input int tid);
    ins_valid = 1; ins_pc = pc; ins_seq = 16'(seq); ins_tid = 1'(tid);
    tick(); ins_valid = 0;
  endtask
  task automatic do_vio(input logic [31:0] spc, input logic [31:0] lpc);
    vio_valid = 1; vio_store_pc = spc; vio_load_pc = lpc;
    tick(); vio_valid = 0;
  endtask
  task automatic do_iss(input logic [31:0] pc, input int seq);
    iss_valid = 1; iss_pc = pc; iss_seq = 16'(seq);
    tick(); iss_valid = 0;
  endtask
  task automatic do_sq(input int tid, input int seq);
    sq_valid = 1; sq_tid = 1'(tid); sq_seq = 16'(seq);
    tick(); sq_valid = 0;
  endtask
  task automatic look(input logic [31:0] pc, input int exp, input string tag);
    lk_valid = 1; lk_pc = pc;
    @(negedge clk);
    check(rsp_valid && int'(rsp_seq) == exp, tag, int'(rsp_seq), exp);
    #1 lk_valid = 0;
  endtask

  localparam logic [31:0] S1 = 32'h013, L1 = 32'h020, S2 = 32'h045;
  localparam logic [31:0] S3 = 32'h0A9, L3 = 32'h0B0, S4 = 32'h0C6, L4 = 32'h0D0;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!rsp_valid && lk_ready, "R1 idle after reset", int'(rsp_valid), 0);
    #1;
    look(S1, 0, "R1 empty lookup");
    do_ins(S1, 10, 0);
    look(S1, 0, "R4 insert without trained entry");
    do_vio(S1, L1);
    look(L1, 0, "R3 trained but no store recorded");
    do_ins(S1, 11, 0);
    look(L1, 11, "R5 store hash shared with load");
    look(L1 + 32'd1, 11, "R2 low offset bits ignored");
    look(32'h120, 11, "R2 index wraps at table size");
    do_vio(S2, L1);
    do_ins(S2, 12, 0);
    look(L1, 12, "R6 identifier copied to new store");
    do_iss(S2, 11);
    look(L1, 12, "R8 stale issue ignored");
    do_iss(S2, 12);
    look(L1, 0, "R8 matching issue retires entry");
    do_vio(S3, L3);
    do_vio(S4, L4);
    do_ins(S4, 30, 0);
    do_vio(S3, L4);
    look(S3, 30, "R7 merge takes smaller identifier");
    look(L4, 30, "R7 load keeps merged set");
    do_ins(S4, 40, 1);
    do_sq(0, 35);
    look(L4, 40, "R9 other thread untouched");
    do_sq(1, 40);
    look(L4, 40, "R9 boundary number survives");
    do_sq(1, 39);
    look(L4, 0, "R9 younger entry removed");
    // R11: insert and lookup in the same cycle
    ins_valid = 1; ins_pc = S4; ins_seq = 16'd50; ins_tid = 1'b0;
    look(L4, 0, "R11 same-cycle lookup sees old table");
    ins_valid = 0;
    look(L4, 50, "R11 insert visible next request");
    // R13: insert beats issue on the same set
    ins_valid = 1; ins_pc = S4; ins_seq = 16'd60;
    iss_valid = 1; iss_pc = S4; iss_seq = 16'd50;
    tick(); ins_valid = 0; iss_valid = 0;
    look(L4, 60, "R13 insert wins over issue");
    // R12: back-pressure holds the response
    rsp_ready = 0;
    look(L4, 60, "R12 accepted under back-pressure");
    lk_valid = 1; lk_pc = L1;
    do_ins(S4, 70, 0);
    for (int k = 0; k < 3; k++) begin
      check(rsp_valid && rsp_seq == 16'd60 && !lk_ready, "R12 response held", int'(rsp_seq), 60);
      tick();
    end
    lk_valid = 0; rsp_ready = 1;
    tick();
    look(L4, 70, "R12 later request sees update");
    // R10: clear beats insertion and wipes training
    clear = 1; ins_valid = 1; ins_pc = S1; ins_seq = 16'd80;
    tick(); clear = 0; ins_valid = 0;
    look(L1, 0, "R10 clear overrides insert");
    look(L4, 0, "R10 clear empties sets");
    do_ins(S1, 81, 0);
    look(L1, 0, "R10 identifier table cleared");
    repeat (2) tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule